// File: doc/BRIEF.md
# Arithmetic Logic Shift Unit

A purely combinational datapath unit that takes two operand words and a carry bit and produces one result word together with a carry flag and a two's-complement overflow flag. Registers placed before and after it let one register-to-register operation finish in a single clock, since the unit itself holds no state. The operand width is a parameter; 4 and 8 bits are the intended settings, and 8 is the default.

Four select lines steer the unit. The low pair drives the arithmetic and logic sections at the same time. The high pair chooses which result reaches the output: the arithmetic sum, the bitwise logic result, operand A moved one place toward the LSB, or operand A moved one place toward the MSB.

The arithmetic section always adds A, a multiplexed second operand and the carry input. The multiplexer offers B, its complement, all zeros or all ones. With the carry input, this gives eight arithmetic operations. The two shifts take the bit they bring in from their own serial input pins.

Top module: `alsu_core`

## Requirements
- R1: With `unit_sel`=00 and `fn_sel`=00 the result is (A + B + `carry_in`) mod 2^W, and with `fn_sel`=01 it is (A + ~B + `carry_in`) mod 2^W, so `carry_in`=1 gives A − B.
- R2: With `unit_sel`=00, `fn_sel`=10 adds all zeros and `fn_sel`=11 adds all ones. Together with `carry_in` this gives A, A+1, A−1 and A, each reduced mod 2^W.
- R3: In arithmetic mode `ovf` is 1 exactly when the two added words share a sign bit and the result's sign bit differs from it. For W=8, 0x7F+1 gives 0x80 with `ovf`=1, and 0x80−1 gives 0x7F with `ovf`=1.
- R4: In arithmetic mode `carry_out` is bit W of the full-width sum A + Y + `carry_in`. For W=8, 0xFF+1 gives 0x00 with `carry_out`=1 and `ovf`=0.
- R5: With `unit_sel`=01, `fn_sel` 00/01/10/11 yields A AND B, A OR B, A XOR B and NOT A respectively.
- R6: With `unit_sel`=10 the result is A shifted one place toward the LSB, and its MSB equals `shr_fill`.
- R7: With `unit_sel`=11 the result is A shifted one place toward the MSB, and its LSB equals `shl_fill`.
- R8: For `unit_sel` other than 00, both `carry_out` and `ovf` are 0.
- R9: The `unit_sel` encoding is 00 arithmetic, 01 logic, 10 right shift, 11 left shift, and it applies to every `fn_sel` value.
- R10: In logic and shift modes `carry_in` has no effect on `result`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_a | input | W | First operand; also the shift source |
| opnd_b | input | W | Second operand |
| carry_in | input | 1 | Carry into the adder LSB |
| fn_sel | input | 2 | Arithmetic operand select and logic operation select |
| unit_sel | input | 2 | Output section select |
| shr_fill | input | 1 | Bit entering the MSB on a right shift |
| shl_fill | input | 1 | Bit entering the LSB on a left shift |
| result | output | W | Selected result |
| carry_out | output | 1 | Adder carry out; 0 outside arithmetic mode |
| ovf | output | 1 | Signed overflow; 0 outside arithmetic mode |

## Verification
The assertions assume that all inputs are driven to known 0/1 values and are stable whenever they are evaluated, because the unit has no clock and reacts to any input change. The bench changes every input together on the falling clock edge and compares outputs one nanosecond later, so each comparison sees a settled, fully driven vector. The sweep walks every A value against a set of B values that includes the sign-boundary words. It combines these with all sixteen select codes and both carry values, and it derives the serial fill bits from the operands, so every input stays defined.

// File: rtl/alsu_pkg.sv
package alsu_pkg;

    typedef enum logic [1:0] {
        UNIT_ARITH = 2'b00,
        UNIT_LOGIC = 2'b01,
        UNIT_SHR   = 2'b10,
        UNIT_SHL   = 2'b11
    } unit_sel_e;

    typedef enum logic [1:0] {
        YSEL_B    = 2'b00,
        YSEL_NB   = 2'b01,
        YSEL_ZERO = 2'b10,
        YSEL_ONES = 2'b11
    } ysel_e;

    typedef enum logic [1:0] {
        LOP_AND  = 2'b00,
        LOP_OR   = 2'b01,
        LOP_XOR  = 2'b10,
        LOP_NOTA = 2'b11
    } lop_e;

endpackage

// File: rtl/alsu_arith.sv
module alsu_arith
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic [1:0]   fn_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         cmsb_o
);
    localparam int LW = W - 1;

    logic [W-1:0] y_d;
    logic [W-1:0] low_d;
    logic         cmsb_d;

    always_comb begin
        case (ysel_e'(fn_i))
            YSEL_B:    y_d = b_i;
            YSEL_NB:   y_d = ~b_i;
            YSEL_ZERO: y_d = '0;
            default:   y_d = '1;
        endcase
    end

    // lower W-1 bits plus carry into the MSB
    always_comb begin
        low_d  = {1'b0, a_i[LW-1:0]} + {1'b0, y_d[LW-1:0]} + {{LW{1'b0}}, cin_i};
        cmsb_d = low_d[LW];
        sum_o  = {a_i[LW] ^ y_d[LW] ^ cmsb_d, low_d[LW-1:0]};
        cout_o = (a_i[LW] & y_d[LW]) | ((a_i[LW] ^ y_d[LW]) & cmsb_d);
        cmsb_o = cmsb_d;
    end

endmodule

// File: rtl/alsu_logic.sv
module alsu_logic
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [1:0]   fn_i,
    output logic [W-1:0] res_o
);
    // one stage per bit, select shared by all stages
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic bit_d;
        always_comb begin
            case (lop_e'(fn_i))
                LOP_AND: bit_d = a_i[i] & b_i[i];
                LOP_OR:  bit_d = a_i[i] | b_i[i];
                LOP_XOR: bit_d = a_i[i] ^ b_i[i];
                default: bit_d = ~a_i[i];
            endcase
        end
        assign res_o[i] = bit_d;
    end

endmodule

// File: rtl/alsu_shift.sv
module alsu_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic         shr_fill_i,
    input  logic         shl_fill_i,
    output logic [W-1:0] shr_o,
    output logic [W-1:0] shl_o
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == W - 1) begin : g_top
            assign shr_o[i] = shr_fill_i;
        end else begin : g_mid_r
            assign shr_o[i] = a_i[i+1];
        end
        if (i == 0) begin : g_bot
            assign shl_o[i] = shl_fill_i;
        end else begin : g_mid_l
            assign shl_o[i] = a_i[i-1];
        end
    end

endmodule

// File: rtl/alsu_core.sv
module alsu_core
    import alsu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         carry_in,
    input  logic [1:0]   fn_sel,
    input  logic [1:0]   unit_sel,
    input  logic         shr_fill,
    input  logic         shl_fill,
    output logic [W-1:0] result,
    output logic         carry_out,
    output logic         ovf
);
    typedef struct packed {
        logic [W-1:0] res;
        logic         cy;
        logic         v;
    } alsu_out_t;

    logic [W-1:0] arith_sum;
    logic         arith_cout;
    logic         arith_cmsb;
    logic [W-1:0] logic_res;
    logic [W-1:0] shr_res;
    logic [W-1:0] shl_res;
    alsu_out_t    out_d;

    alsu_arith #(.W(W)) u_arith (
        .a_i    (opnd_a),
        .b_i    (opnd_b),
        .cin_i  (carry_in),
        .fn_i   (fn_sel),
        .sum_o  (arith_sum),
        .cout_o (arith_cout),
        .cmsb_o (arith_cmsb)
    );

    alsu_logic #(.W(W)) u_logic (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .fn_i  (fn_sel),
        .res_o (logic_res)
    );

    alsu_shift #(.W(W)) u_shift (
        .a_i        (opnd_a),
        .shr_fill_i (shr_fill),
        .shl_fill_i (shl_fill),
        .shr_o      (shr_res),
        .shl_o      (shl_res)
    );

    always_comb begin
        out_d = '0;
        case (unit_sel_e'(unit_sel))
            UNIT_ARITH: begin
                out_d.res = arith_sum;
                out_d.cy  = arith_cout;
                out_d.v   = arith_cmsb ^ arith_cout;
            end
            UNIT_LOGIC: out_d.res = logic_res;
            UNIT_SHR:   out_d.res = shr_res;
            default:    out_d.res = shl_res;
        endcase
    end

    assign result    = out_d.res;
    assign carry_out = out_d.cy;
    assign ovf       = out_d.v;

endmodule

// File: rtl/alsu_core_chk.sv
module alsu_core_chk #(
    parameter int W = 8
) (
    input logic [W-1:0] opnd_a,
    input logic [W-1:0] opnd_b,
    input logic         carry_in,
    input logic [1:0]   fn_sel,
    input logic [1:0]   unit_sel,
    input logic         shr_fill,
    input logic         shl_fill,
    input logic [W-1:0] result,
    input logic         carry_out,
    input logic         ovf
);
    logic [W-1:0] y_ref;

    always_comb begin
        case (fn_sel)
            2'b00:   y_ref = opnd_b;
            2'b01:   y_ref = ~opnd_b;
            2'b10:   y_ref = '0;
            default: y_ref = '1;
        endcase
    end

    always_comb begin
        if (unit_sel != 2'b00) begin
            p_flags_zero_r8: assert (!carry_out && !ovf)
                else $error("flags set outside arithmetic mode");
        end
        if (unit_sel == 2'b00) begin
            p_ovf_sign_r3: assert (ovf == ((opnd_a[W-1] == y_ref[W-1]) && (result[W-1] != opnd_a[W-1])))
                else $error("signed overflow flag wrong");
        end
        if (unit_sel == 2'b10) begin
            p_shr_fill_r6: assert (result == {shr_fill, opnd_a[W-1:1]})
                else $error("right shift wrong");
        end
        if (unit_sel == 2'b11) begin
            p_shl_fill_r7: assert (result == {opnd_a[W-2:0], shl_fill})
                else $error("left shift wrong");
        end
        if (unit_sel == 2'b01 && fn_sel == 2'b11) begin
            p_not_a_r5: assert (result == ~opnd_a)
                else $error("NOT A wrong");
        end
        if (unit_sel == 2'b00 && fn_sel == 2'b10 && !carry_in) begin
            p_transfer_r2: assert (result == opnd_a && !carry_out)
                else $error("transfer wrong");
        end
    end

endmodule

bind alsu_core alsu_core_chk #(.W(W)) u_chk (
    .opnd_a    (opnd_a),
    .opnd_b    (opnd_b),
    .carry_in  (carry_in),
    .fn_sel    (fn_sel),
    .unit_sel  (unit_sel),
    .shr_fill  (shr_fill),
    .shl_fill  (shl_fill),
    .result    (result),
    .carry_out (carry_out),
    .ovf       (ovf)
);

// File: tb/alsu_core_tb_top.sv
module alsu_core_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] opnd_a = '0;
    logic [W-1:0] opnd_b = '0;
    logic         carry_in = 1'b0;
    logic [1:0]   fn_sel = '0;
    logic [1:0]   unit_sel = '0;
    logic         shr_fill = 1'b0;
    logic         shl_fill = 1'b0;
    logic [W-1:0] result;
    logic         carry_out;
    logic         ovf;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    alsu_core #(.W(W)) dut_i (
        .opnd_a    (opnd_a),
        .opnd_b    (opnd_b),
        .carry_in  (carry_in),
        .fn_sel    (fn_sel),
        .unit_sel  (unit_sel),
        .shr_fill  (shr_fill),
        .shl_fill  (shl_fill),
        .result    (result),
        .carry_out (carry_out),
        .ovf       (ovf)
    );

    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic ci,
                         input logic [1:0] fs, input logic [1:0] us,
                         input logic fr, input logic fl);
        @(negedge clk);
        opnd_a = a; opnd_b = b; carry_in = ci;
        fn_sel = fs; unit_sel = us; shr_fill = fr; shl_fill = fl;
        #1;
    endtask

    task automatic check(input string tag, input logic [W-1:0] er,
                         input logic ec, input logic ev);
        total++;
        if (result !== er || carry_out !== ec || ovf !== ev) begin
            bad++;
            $display("FAIL %s: a=%h b=%h ci=%b fn=%b unit=%b got res=%h c=%b v=%b exp res=%h c=%b v=%b",
                     tag, opnd_a, opnd_b, carry_in, fn_sel, unit_sel,
                     result, carry_out, ovf, er, ec, ev);
        end
    endtask

    // reference computed from the requirement text
    task automatic expect_now(output logic [W-1:0] er, output logic ec,
                              output logic ev, output string tag);
        logic [W-1:0] y;
        logic [W:0]   full;
        er = '0; ec = 1'b0; ev = 1'b0;
        case (unit_sel)
            2'b00: begin
                case (fn_sel)
                    2'b00: begin y = opnd_b;  tag = "R1 R3 R4 R9"; end
                    2'b01: begin y = ~opnd_b; tag = "R1 R3 R4 R9"; end
                    2'b10: begin y = '0;      tag = "R2 R3 R4 R9"; end
                    default: begin y = '1;    tag = "R2 R3 R4 R9"; end
                endcase
                full = {1'b0, opnd_a} + {1'b0, y} + {{W{1'b0}}, carry_in};
                er = full[W-1:0];
                ec = full[W];
                ev = (opnd_a[W-1] == y[W-1]) && (er[W-1] != opnd_a[W-1]);
            end
            2'b01: begin
                tag = "R5 R8 R9";
                case (fn_sel)
                    2'b00: er = opnd_a & opnd_b;
                    2'b01: er = opnd_a | opnd_b;
                    2'b10: er = opnd_a ^ opnd_b;
                    default: er = ~opnd_a;
                endcase
            end
            2'b10: begin
                tag = "R6 R8 R9";
                er = (opnd_a >> 1) | ({{(W-1){1'b0}}, shr_fill} << (W-1));
            end
            default: begin
                tag = "R7 R8 R9";
                er = (opnd_a << 1) | {{(W-1){1'b0}}, shl_fill};
            end
        endcase
    endtask

    initial begin : watchdog
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                bad++;
                total++;
                $display("FAIL watchdog: run exceeded %0d cycles, expected completion", cycles);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin : stim
        logic [W-1:0] er;
        logic         ec;
        logic         ev;
        logic [W-1:0] r0;
        string        tag;
        logic [W-1:0] bset [8];
        bset[0] = 8'h00; bset[1] = 8'h01; bset[2] = 8'h7F; bset[3] = 8'h80;
        bset[4] = 8'hFF; bset[5] = 8'h5A; bset[6] = 8'hC3; bset[7] = 8'h36;

        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // reset-state vector: all-zero inputs give zero outputs (R1)
        apply('0, '0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0);
        check("R1 idle", 8'h00, 1'b0, 1'b0);

        // overflow and carry corners (R3, R4)
        apply(8'h7F, 8'h01, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0);
        check("R3 7F+1", 8'h80, 1'b0, 1'b1);
        apply(8'h7F, 8'h00, 1'b1, 2'b10, 2'b00, 1'b0, 1'b0);
        check("R3 7F inc", 8'h80, 1'b0, 1'b1);
        apply(8'h80, 8'h00, 1'b0, 2'b11, 2'b00, 1'b0, 1'b0);
        check("R3 80 dec", 8'h7F, 1'b1, 1'b1);
        apply(8'h80, 8'h01, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0);
        check("R3 80-1 sub", 8'h7F, 1'b1, 1'b1);
        apply(8'hFF, 8'h01, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0);
        check("R4 FF+1", 8'h00, 1'b1, 1'b0);
        apply(8'h05, 8'h03, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0);
        check("R1 5-3", 8'h02, 1'b1, 1'b0);
        apply(8'h3C, 8'h00, 1'b1, 2'b11, 2'b00, 1'b0, 1'b0);
        check("R2 transfer 111", 8'h3C, 1'b1, 1'b0);

        // shift fill bits (R6, R7)
        apply(8'h81, 8'h00, 1'b0, 2'b00, 2'b10, 1'b1, 1'b0);
        check("R6 fill1", 8'hC0, 1'b0, 1'b0);
        apply(8'h81, 8'h00, 1'b0, 2'b00, 2'b11, 1'b0, 1'b1);
        check("R7 fill1", 8'h03, 1'b0, 1'b0);

        // carry_in ignored by logic and shift (R10)
        for (int u = 1; u < 4; u++) begin
            for (int f = 0; f < 4; f++) begin
                apply(8'hA7, 8'h3C, 1'b0, 2'(f), 2'(u), 1'b1, 1'b1);
                r0 = result;
                apply(8'hA7, 8'h3C, 1'b1, 2'(f), 2'(u), 1'b1, 1'b1);
                check("R10 cin ignored", r0, 1'b0, 1'b0);
            end
        end

        // sweep: every A, selected B, all selects, both carries
        for (int a = 0; a < 256; a++) begin
            for (int bi = 0; bi < 8; bi++) begin
                for (int s = 0; s < 16; s++) begin
                    for (int c = 0; c < 2; c++) begin
                        apply(8'(a), bset[bi], 1'(c), 2'(s & 3), 2'(s >> 2),
                              1'(a ^ bi), 1'((a >> 1) ^ c));
                        expect_now(er, ec, ev, tag);
                        check(tag, er, ec, ev);
                    end
                end
            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule